// File: doc/BRIEF.md
# Bypass Path Allocation Queue

This block keeps the books for detour paths built in a layer of configurable bypass links that sit beside a mesh network. Some routers may be powered down, and traffic must then go around them. A path finder, which lies outside this block, proposes a candidate path for a flow. Candidate paths follow dimension-ordered routing so that they cannot deadlock. The path arrives as a flow identifier and a bit mask with one bit for each bypass link in the mesh. The block admits the path only if all of its links are free. It then stores the flow and its mask in one slot of a fixed-depth table and marks those links as taken.

A path that touches even one taken link is refused. The same holds when the table is full or when the flow already owns a path. The source must hold the flow and try again later. After a flow has finished sending, a release command that carries its identifier clears its slot and returns its links to the pool. If a release and a request arrive in the same cycle, the release takes effect first. The request can therefore reuse the links or the slot that were just freed.

Top module: `bypass_path_alloc`

## Requirements
- R1: After reset no path is stored: `occupied` is all zero, `queueFull` is 0 and `rspValid` is 0.
- R2: A request sampled at a clock edge gets exactly one response, with `rspValid` high for one cycle after that edge and `rspFlow` equal to the requested flow. `rspValid` is 0 in any cycle that follows an edge without a request.
- R3: A request whose mask shares no bit with the occupied links, whose flow is not stored and that finds a free slot is granted (`rspGrant`=1, `rspErr`=0). Its mask bits are set in `occupied` from the same cycle as the response.
- R4: A request whose mask shares at least one bit with `occupied` is answered as blocked (`rspGrant`=0, `rspErr`=0), and `occupied` does not change.
- R5: A release whose flow matches a stored entry clears that entry and its mask bits in `occupied` from the next cycle on. A release for a flow that is not stored has no effect.
- R6: When a release and a request fall in the same cycle, the release is applied first. Links, the slot and the flow identifier that the release frees are all available to that request.
- R7: A request whose flow identifier is already stored is answered as blocked with `rspErr`=1, and the stored entry and `occupied` stay as they were.
- R8: With DEPTH entries stored, `queueFull` is 1 and a request is answered as blocked with `rspErr`=0, even if its links are free. A release in the same cycle lets that request be granted.
- R9: A request with an all-zero mask is granted when a slot is free and the flow is new, and it occupies a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Path request strobe |
| reqFlow | input | FLOW_W | Flow identifier of the request |
| reqMask | input | LINK_N | Bypass links needed by the candidate path, one bit per link |
| relValid | input | 1 | Release strobe |
| relFlow | input | FLOW_W | Flow identifier whose path is released |
| rspValid | output | 1 | Response strobe, one cycle after a request |
| rspGrant | output | 1 | 1 = path granted, 0 = blocked |
| rspErr | output | 1 | Blocked because the flow already holds a path |
| rspFlow | output | FLOW_W | Flow identifier the response belongs to |
| occupied | output | LINK_N | Bypass links currently in use |
| queueFull | output | 1 | All DEPTH slots hold a path |

## Verification
A release and a request can land in the same clock cycle. Whether the request succeeds then depends on seeing the table as it stands after the release. The bench provokes this in three ways. In the first, the request needs a link that was held only by the flow being released. In the second, it reuses the identifier of the flow being released. In the third, the table is full and the release frees the only slot. In each case the bench expects a grant rather than a block or a duplicate error, and it checks the `occupied` mask that results the cycle after.

// File: rtl/bpa_pkg.sv
package bpa_pkg;
  typedef struct packed {
    logic wrEn;
    logic clrEn;
  } tblStrobe_t;
endpackage

// File: rtl/bpa_table.sv
module bpa_table #(
  parameter int FLOW_W = 6,
  parameter int LINK_N = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  bpa_pkg::tblStrobe_t strobe,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [IDX_W-1:0]    clrIdx,
  input  logic [FLOW_W-1:0]   wrFlow,
  input  logic [LINK_N-1:0]   wrMask,
  input  logic [FLOW_W-1:0]   reqFlow,
  input  logic                relValid,
  input  logic [FLOW_W-1:0]   relFlow,
  output logic [DEPTH-1:0]    entValid,
  output logic [DEPTH-1:0]    reqHit,
  output logic [DEPTH-1:0]    relHit,
  output logic [LINK_N-1:0]   occAll,
  output logic [LINK_N-1:0]   occKeep
);
  logic [FLOW_W-1:0] entFlow [DEPTH];
  logic [LINK_N-1:0] entMask [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entFlow[i]  <= '0;
        entMask[i]  <= '0;
      end else if (strobe.wrEn && wrIdx == IDX_W'(i)) begin
        entValid[i] <= 1'b1;
        entFlow[i]  <= wrFlow;
        entMask[i]  <= wrMask;
      end else if (strobe.clrEn && clrIdx == IDX_W'(i)) begin
        entValid[i] <= 1'b0;
      end
    end
    assign reqHit[i] = entValid[i] && (entFlow[i] == reqFlow);
    assign relHit[i] = relValid && entValid[i] && (entFlow[i] == relFlow);
  end

  always_comb begin
    occAll  = '0;
    occKeep = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entValid[i]) occAll = occAll | entMask[i];
      if (entValid[i] && !relHit[i]) occKeep = occKeep | entMask[i];
    end
  end

  // R3
  granted_links_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |=> ((occAll & $past(wrMask)) == $past(wrMask)));
  // R5
  clear_hits_stored_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrEn |-> entValid[clrIdx]);
  // R8
  write_free_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && !(strobe.clrEn && clrIdx == wrIdx)) |-> !entValid[wrIdx]);
endmodule

// File: rtl/bpa_ctrl.sv
module bpa_ctrl #(
  parameter int FLOW_W = 6,
  parameter int LINK_N = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [FLOW_W-1:0]   reqFlow,
  input  logic [LINK_N-1:0]   reqMask,
  input  logic [DEPTH-1:0]    entValid,
  input  logic [DEPTH-1:0]    reqHit,
  input  logic [DEPTH-1:0]    relHit,
  input  logic [LINK_N-1:0]   occKeep,
  output bpa_pkg::tblStrobe_t strobe,
  output logic [IDX_W-1:0]    wrIdx,
  output logic [IDX_W-1:0]    clrIdx,
  output logic                rspValid,
  output logic                rspGrant,
  output logic                rspErr,
  output logic [FLOW_W-1:0]   rspFlow
);
  logic [DEPTH-1:0] keepVec;
  logic isDup, isFull, isOverlap, doGrant;

  assign keepVec   = entValid & ~relHit;
  assign isDup     = |(reqHit & keepVec);
  assign isFull    = &keepVec;
  assign isOverlap = |(reqMask & occKeep);
  assign doGrant   = reqValid && !isDup && !isFull && !isOverlap;

  always_comb begin
    wrIdx  = '0;
    clrIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!keepVec[i]) wrIdx = IDX_W'(i);
      if (relHit[i])   clrIdx = IDX_W'(i);
    end
    strobe.wrEn  = doGrant;
    strobe.clrEn = |relHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspGrant <= 1'b0;
      rspErr   <= 1'b0;
      rspFlow  <= '0;
    end else begin
      rspValid <= reqValid;
      rspGrant <= doGrant;
      rspErr   <= reqValid && isDup;
      rspFlow  <= reqValid ? reqFlow : rspFlow;
    end
  end

  // R2
  one_response_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspValid && rspFlow == $past(reqFlow)));
  // R7
  err_not_granted_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && !rspGrant));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&keepVec) |-> !strobe.wrEn);
  // R5
  single_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(relHit));
endmodule

// File: rtl/bypass_path_alloc.sv
module bypass_path_alloc #(
  parameter int FLOW_W = 6,
  parameter int LINK_N = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [FLOW_W-1:0] reqFlow,
  input  logic [LINK_N-1:0] reqMask,
  input  logic              relValid,
  input  logic [FLOW_W-1:0] relFlow,
  output logic              rspValid,
  output logic              rspGrant,
  output logic              rspErr,
  output logic [FLOW_W-1:0] rspFlow,
  output logic [LINK_N-1:0] occupied,
  output logic              queueFull
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  bpa_pkg::tblStrobe_t strobe;
  logic [IDX_W-1:0]  wrIdx, clrIdx;
  logic [DEPTH-1:0]  entValid, reqHit, relHit;
  logic [LINK_N-1:0] occKeep;

  bpa_table #(.FLOW_W(FLOW_W), .LINK_N(LINK_N), .DEPTH(DEPTH)) i_table (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrIdx(wrIdx), .clrIdx(clrIdx),
    .wrFlow(reqFlow), .wrMask(reqMask), .reqFlow(reqFlow),
    .relValid(relValid), .relFlow(relFlow), .entValid(entValid),
    .reqHit(reqHit), .relHit(relHit), .occAll(occupied), .occKeep(occKeep)
  );

  bpa_ctrl #(.FLOW_W(FLOW_W), .LINK_N(LINK_N), .DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFlow(reqFlow),
    .reqMask(reqMask), .entValid(entValid), .reqHit(reqHit), .relHit(relHit),
    .occKeep(occKeep), .strobe(strobe), .wrIdx(wrIdx), .clrIdx(clrIdx),
    .rspValid(rspValid), .rspGrant(rspGrant), .rspErr(rspErr), .rspFlow(rspFlow)
  );

  assign queueFull = &entValid;

  // R4
  blocked_keeps_links_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspGrant && !$past(relValid)) |-> (occupied == $past(occupied)));
endmodule

// File: tb/test_bypass_path_alloc.sv
module test_bypass_path_alloc;
  localparam int FW = 6;
  localparam int LN = 32;
  localparam int DP = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, relValid = 1'b0;
  logic [FW-1:0] reqFlow = '0, relFlow = '0;
  logic [LN-1:0] reqMask = '0;
  logic rspValid, rspGrant, rspErr, queueFull;
  logic [FW-1:0] rspFlow;
  logic [LN-1:0] occupied;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bypass_path_alloc #(.FLOW_W(FW), .LINK_N(LN), .DEPTH(DP)) i_bypass_path_alloc (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqFlow(reqFlow),
    .reqMask(reqMask), .relValid(relValid), .relFlow(relFlow),
    .rspValid(rspValid), .rspGrant(rspGrant), .rspErr(rspErr),
    .rspFlow(rspFlow), .occupied(occupied), .queueFull(queueFull)
  );

  typedef struct packed {
    logic          rv;
    logic [FW-1:0] rf;
    logic          qv;
    logic [FW-1:0] qf;
    logic [LN-1:0] qm;
    logic          eV;
    logic          eG;
    logic          eE;
    logic [LN-1:0] eOcc;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 6'd0, 1'b1, 6'd1, 32'h0000000F, 1'b1, 1'b1, 1'b0, 32'h0000000F}, // R3
    '{1'b0, 6'd0, 1'b1, 6'd2, 32'h00000030, 1'b1, 1'b1, 1'b0, 32'h0000003F}, // R3
    '{1'b0, 6'd0, 1'b1, 6'd3, 32'h00000018, 1'b1, 1'b0, 1'b0, 32'h0000003F}, // R4
    '{1'b0, 6'd0, 1'b1, 6'd1, 32'h00000100, 1'b1, 1'b0, 1'b1, 32'h0000003F}, // R7
    '{1'b1, 6'd9, 1'b0, 6'd0, 32'h00000000, 1'b0, 1'b0, 1'b0, 32'h0000003F}, // R5 absent
    '{1'b1, 6'd1, 1'b1, 6'd3, 32'h0000000C, 1'b1, 1'b1, 1'b0, 32'h0000003C}, // R6 links
    '{1'b1, 6'd2, 1'b1, 6'd2, 32'h00000040, 1'b1, 1'b1, 1'b0, 32'h0000004C}, // R6 flow id
    '{1'b0, 6'd0, 1'b1, 6'd4, 32'h00000000, 1'b1, 1'b1, 1'b0, 32'h0000004C}, // R9
    '{1'b1, 6'd3, 1'b0, 6'd0, 32'h00000000, 1'b0, 1'b0, 1'b0, 32'h00000040}  // R5
  };

  task automatic check(input string req, input logic [LN-1:0] act, input logic [LN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rv, input logic [FW-1:0] rf,
                       input logic qv, input logic [FW-1:0] qf, input logic [LN-1:0] qm);
    relValid = rv; relFlow = rf; reqValid = qv; reqFlow = qf; reqMask = qm;
    @(negedge clk);
    relValid = 1'b0; reqValid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    check("R1 occupied", occupied, '0);
    check("R1 queueFull", LN'(queueFull), '0);
    check("R1 rspValid", LN'(rspValid), '0);

    for (int i = 0; i < 9; i++) begin
      drive(VECS[i].rv, VECS[i].rf, VECS[i].qv, VECS[i].qf, VECS[i].qm);
      check("R2 rspValid", LN'(rspValid), LN'(VECS[i].eV));
      if (VECS[i].eV) begin
        check("R2 rspFlow", LN'(rspFlow), LN'(VECS[i].qf));
        check("R3/R4 rspGrant", LN'(rspGrant), LN'(VECS[i].eG));
        check("R7 rspErr", LN'(rspErr), LN'(VECS[i].eE));
      end
      check("R5 occupied", occupied, VECS[i].eOcc);
    end

    // empty the table: flows 2 and 4 remain
    drive(1'b1, 6'd2, 1'b0, 6'd0, '0);
    drive(1'b1, 6'd4, 1'b0, 6'd0, '0);
    check("R5 occupied cleared", occupied, '0);

    // R8 fill all slots
    for (int i = 0; i < DP; i++) begin
      drive(1'b0, 6'd0, 1'b1, FW'(10 + i), LN'(1) << i);
      check("R8 fill grant", LN'(rspGrant), LN'(1));
    end
    check("R8 queueFull", LN'(queueFull), LN'(1));
    check("R8 occupied full", occupied, 32'h0000FFFF);

    drive(1'b0, 6'd0, 1'b1, 6'd30, 32'h00100000);
    check("R8 full blocked grant", LN'(rspGrant), '0);
    check("R8 full blocked err", LN'(rspErr), '0);
    check("R8 full occupied unchanged", occupied, 32'h0000FFFF);

    // R6 R8 release frees the only slot for the same-cycle request
    drive(1'b1, 6'd10, 1'b1, 6'd30, 32'h00100000);
    check("R6 full release grant", LN'(rspGrant), LN'(1));
    check("R6 full release occupied", occupied, 32'h0010FFFE);
    check("R8 still full", LN'(queueFull), LN'(1));

    // R2 idle cycle yields no response
    @(negedge clk);
    check("R2 idle rspValid", LN'(rspValid), '0);

    finish_run();
  end
endmodule